// File: doc/BRIEF.md
# Countdown and Watchdog Tick Timer

This block is a small timer for an always-on domain. An 8-bit down-counter steps once for each strobe of one tick source, chosen from several strobe inputs that each stand for a different reference frequency. A 2-bit mode field picks between two behaviours. In periodic countdown mode, the counter reloads itself when it reaches zero and keeps running. In one-shot watchdog mode, it parks at zero until software writes it again.

Each behaviour has its own event flag, interrupt enable and interrupt output. The countdown flag stays set until software writes a 0 to it. The watchdog flag cannot be written: reading the status register clears it. One control bit sets how both interrupt outputs behave. As a level, the output follows the enabled flag. As a pulse, it is high from the event until the next strobe of the selected source.

Software reaches the block through a simple register port with a 2-bit address. Register map (address: fields):
- 0: mode in bits [1:0] (01 = countdown, 10 = watchdog, 00 or 11 = stopped); pulse select in bit 2 (1 = pulse).
- 1: source select in bits [2:0].
- 2: a write loads the reload value and the counter; a read returns the live count.
- 3 (status): countdown flag in bit 0, watchdog flag in bit 1, countdown enable in bit 4, watchdog enable in bit 5.

Top module: `tick_wdog_timer`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: A write to address 2 sets both the reload value and the counter to the written byte; a read of address 2 returns the live counter value.
- R3: The counter decrements only in a cycle where the strobe selected by address 1 bits [2:0] is high; strobes on other sources have no effect on it.
- R4: In countdown mode (address 0 bits [1:0] = 01), a strobe that takes the counter from 1 to zero sets status bit 0 and loads the counter with the reload value, so counting continues.
- R5: In watchdog mode (address 0 bits [1:0] = 10), a strobe that takes the counter from 1 to zero sets status bit 1 and leaves the counter at 0 until address 2 is written again, which restarts it.
- R6: With mode 00 or 11, the counter holds its value whatever the strobes do.
- R7: Reading address 3 clears status bit 1, and writes never change that bit. Status bit 0 clears only on a write to address 3 with data bit 0 = 0; writing 1 to it leaves it unchanged.
- R8: In level output (address 0 bit 2 = 0), irq_cd_o equals status bit 0 AND enable bit 4, and irq_wd_o equals status bit 1 AND enable bit 5.
- R9: In pulse output (address 0 bit 2 = 1), an enabled interrupt output rises after its event and falls at the next selected strobe. The flag itself stays set.
- R10: When an event and a clear of the same flag fall in one cycle, the flag ends up set.
- R11: A counter value of 0 is idle in both modes: strobes raise no flag and leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (drives the read-clear of the watchdog flag) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| tick_i | input | 5 | One single-cycle strobe per source frequency |
| irq_cd_o | output | 1 | Countdown interrupt |
| irq_wd_o | output | 1 | Watchdog interrupt |

## Verification
The bench goes after the terminal step in both modes. A design that mixed up the two modes would either rearm the watchdog or park the countdown. It also drives strobes on sources that are not selected and strobes while the mode is stopped; a wrong source mux or a missing mode gate would move the counter there. It places an event in the same cycle as a status read and as a clearing write. A design that let the clear win would lose the event. Pulse mode is checked to end exactly at the next selected strobe while the flag stays set, and the watchdog flag is checked to ignore writes but fall after one read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_CD   = 2'b01,
    MODE_WD   = 2'b10,
    MODE_OFF3 = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_VAL  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int STAT_CD_FLAG = 0;
  localparam int STAT_WD_FLAG = 1;
  localparam int STAT_CD_IE   = 4;
  localparam int STAT_WD_IE   = 5;
  localparam int CTRL_PULSE   = 2;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  // selections beyond NUM_SRC-1 never tick
  assign tick_o = |hit;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cd_evt_o,
  output logic             wd_evt_o
);
  logic [CNT_W-1:0] count_q, reload_q;
  logic             active, step, term;

  assign active = (mode_i == MODE_CD) || (mode_i == MODE_WD);
  assign step   = active && tick_i && !load_i && (count_q != '0);
  assign term   = step && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      count_q  <= load_val_i;
      reload_q <= load_val_i;
    end else if (term) begin
      count_q <= (mode_i == MODE_CD) ? reload_q : '0;
    end else if (step) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  assign count_o  = count_q;
  assign cd_evt_o = term && (mode_i == MODE_CD);
  assign wd_evt_o = term && (mode_i == MODE_WD);

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(load_val_i)); // R2
  AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(count_q)); // R3
  AST_CD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CD && tick_i && !load_i && count_q == CNT_W'(1))
      |=> count_q == $past(reload_q)); // R4
  AST_WD_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_WD && !load_i && count_q == '0) |=> count_q == '0); // R5
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !load_i) |=> $stable(count_q)); // R6
endmodule

// File: rtl/wdt_irq_chan.sv
module wdt_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic pulse_mode_i,
  input  logic tick_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (evt_i)      flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
      if (evt_i)       pulse_q <= 1'b1;
      else if (tick_i) pulse_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = ie_i && (pulse_mode_i ? pulse_q : flag_q);

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_i); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R7
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && tick_i && !evt_i) |=> (!pulse_mode_i || !irq_o)); // R9
endmodule

// File: rtl/tick_wdog_timer.sv
module tick_wdog_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         addr_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               irq_cd_o,
  output logic               irq_wd_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  mode_e            mode_q;
  logic             pulse_sel_q, cd_ie_q, wd_ie_q;
  logic [SEL_W-1:0] src_q;
  logic             tick_sel, load, cd_evt, wd_evt;
  logic             cd_clr, wd_clr, cd_flag, wd_flag;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_OFF;
      pulse_sel_q <= 1'b0;
      src_q       <= '0;
      cd_ie_q     <= 1'b0;
      wd_ie_q     <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          mode_q      <= mode_e'(wdata_i[1:0]);
          pulse_sel_q <= wdata_i[CTRL_PULSE];
        end
        ADDR_SRC:  src_q <= wdata_i[SEL_W-1:0];
        ADDR_STAT: begin
          cd_ie_q <= wdata_i[STAT_CD_IE];
          wd_ie_q <= wdata_i[STAT_WD_IE];
        end
        default: ;
      endcase
    end
  end

  assign load   = we_i && (addr_i == ADDR_VAL);
  assign cd_clr = we_i && (addr_i == ADDR_STAT) && !wdata_i[STAT_CD_FLAG];
  assign wd_clr = re_i && (addr_i == ADDR_STAT);

  wdt_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .tick_i (tick_i),
    .sel_i  (src_q),
    .tick_o (tick_sel)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .tick_i     (tick_sel),
    .load_i     (load),
    .load_val_i (wdata_i),
    .count_o    (count),
    .cd_evt_o   (cd_evt),
    .wd_evt_o   (wd_evt)
  );

  wdt_irq_chan u_cd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (cd_evt),
    .clr_i        (cd_clr),
    .ie_i         (cd_ie_q),
    .pulse_mode_i (pulse_sel_q),
    .tick_i       (tick_sel),
    .flag_o       (cd_flag),
    .irq_o        (irq_cd_o)
  );

  wdt_irq_chan u_wd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (wd_evt),
    .clr_i        (wd_clr),
    .ie_i         (wd_ie_q),
    .pulse_mode_i (pulse_sel_q),
    .tick_i       (tick_sel),
    .flag_o       (wd_flag),
    .irq_o        (irq_wd_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[1:0]        = mode_q;
        rdata_o[CTRL_PULSE] = pulse_sel_q;
      end
      ADDR_SRC: rdata_o[SEL_W-1:0] = src_q;
      ADDR_VAL: rdata_o = count;
      default: begin
        rdata_o[STAT_CD_FLAG] = cd_flag;
        rdata_o[STAT_WD_FLAG] = wd_flag;
        rdata_o[STAT_CD_IE]   = cd_ie_q;
        rdata_o[STAT_WD_IE]   = wd_ie_q;
      end
    endcase
  end

  AST_WD_FLAG_NO_WRITE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_flag && !wd_evt) |=> !wd_flag); // R7
  AST_WD_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_clr && !wd_evt) |=> !wd_flag); // R7
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cd_evt && wd_evt)); // R4
endmodule

// File: tb/sim_tick_wdog_timer.sv
`timescale 1ns/100ps
module sim_tick_wdog_timer;
  localparam int SRC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] tick = '0;
  logic       irq_cd, irq_wd;

  int checks = 0;
  int failures = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  tick_wdog_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .irq_cd_o(irq_cd), .irq_wd_o(irq_wd)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && re) begin
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: got %02h expected none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          failures++;
          $display("FAIL %s: rdata=%02h expected=%02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic w, input logic r, input logic [1:0] a,
                       input logic [7:0] d, input logic [4:0] t);
    @(posedge clk); #1;
    we = w; re = r; addr = a; wdata = d; tick = t;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'd0, 8'h00, 5'b0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drive(1'b1, 1'b0, a, d, 5'b0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    drive(1'b0, 1'b1, a, 8'h00, 5'b0);
  endtask

  task automatic tk(input int s);
    drive(1'b0, 1'b0, 2'd0, 8'h00, 5'(1 << s));
  endtask

  task automatic chk_irq(input logic e_cd, input logic e_wd, input string tag);
    idle();
    checks++;
    if (irq_cd !== e_cd || irq_wd !== e_wd) begin
      failures++;
      $display("FAIL %s: irq_cd=%0b irq_wd=%0b expected %0b %0b",
               tag, irq_cd, irq_wd, e_cd, e_wd);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 8'h00, "R1 ctrl");
        rd(2'd1, 8'h00, "R1 src");
        rd(2'd2, 8'h00, "R1 value");
        rd(2'd3, 8'h00, "R1 status");
        chk_irq(1'b0, 1'b0, "R1 irq");
        // R2 load, R6 freeze in mode 00
        wr(2'd1, 8'(SRC));
        wr(2'd3, 8'h30);
        wr(2'd2, 8'd3);
        rd(2'd2, 8'd3, "R2 load");
        tk(SRC); tk(SRC);
        rd(2'd2, 8'd3, "R6 mode 00 freeze");
        // R3 countdown stepping, other sources ignored
        wr(2'd0, 8'h01);
        tk(1); tk(4);
        rd(2'd2, 8'd3, "R3 other source ignored");
        tk(SRC);
        rd(2'd2, 8'd2, "R3 step 1");
        tk(SRC);
        rd(2'd2, 8'd1, "R3 step 2");
        tk(SRC);
        rd(2'd3, 8'h31, "R4 cd flag set");
        rd(2'd2, 8'd3, "R4 reload");
        chk_irq(1'b1, 1'b0, "R8 cd level irq");
        // R7 cd flag clear rules
        rd(2'd3, 8'h31, "R7 cd flag survives read");
        wr(2'd3, 8'h31);
        rd(2'd3, 8'h31, "R7 write 1 keeps cd flag");
        wr(2'd3, 8'h30);
        rd(2'd3, 8'h30, "R7 write 0 clears cd flag");
        chk_irq(1'b0, 1'b0, "R8 irq low after clear");
        // R8 enable gating
        wr(2'd3, 8'h20);
        tk(SRC); tk(SRC); tk(SRC);
        rd(2'd3, 8'h21, "R4 cd flag second period");
        chk_irq(1'b0, 1'b0, "R8 cd irq masked");
        wr(2'd3, 8'h30);
        // R5 watchdog
        wr(2'd0, 8'h02);
        wr(2'd2, 8'd2);
        tk(SRC); tk(SRC);
        rd(2'd2, 8'd0, "R5 wd parks at 0");
        chk_irq(1'b0, 1'b1, "R8 wd level irq");
        tk(SRC); tk(SRC);
        rd(2'd2, 8'd0, "R5 wd stays 0");
        wr(2'd3, 8'h30);
        rd(2'd3, 8'h32, "R7 write does not clear wd flag");
        rd(2'd3, 8'h30, "R7 read cleared wd flag");
        chk_irq(1'b0, 1'b0, "R7 wd irq low after read");
        wr(2'd2, 8'd1);
        tk(SRC);
        rd(2'd3, 8'h32, "R5 rewrite restarts wd");
        // R9 pulse output
        wr(2'd0, 8'h06);
        rd(2'd0, 8'h06, "R9 ctrl readback");
        wr(2'd2, 8'd1);
        tk(SRC);
        chk_irq(1'b0, 1'b1, "R9 pulse rises");
        chk_irq(1'b0, 1'b1, "R9 pulse held between ticks");
        tk(SRC);
        chk_irq(1'b0, 1'b0, "R9 pulse falls at next tick");
        rd(2'd3, 8'h32, "R9 flag stays after pulse");
        // R10 set wins over clear
        wr(2'd0, 8'h01);
        wr(2'd2, 8'd1);
        tk(SRC);
        drive(1'b1, 1'b0, 2'd3, 8'h30, 5'(1 << SRC));
        rd(2'd3, 8'h31, "R10 cd set beats write clear");
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h02);
        wr(2'd2, 8'd1);
        begin
          item_t it;
          it.exp = 8'h30; it.tag = "R10 read in event cycle";
          sb_q.push_back(it);
        end
        drive(1'b0, 1'b1, 2'd3, 8'h00, 5'(1 << SRC));
        rd(2'd3, 8'h32, "R10 wd set beats read clear");
        rd(2'd3, 8'h30, "R10 wd cleared by next read");
        // R6 mode 11 freeze
        wr(2'd0, 8'h03);
        wr(2'd2, 8'd5);
        tk(SRC); tk(SRC);
        rd(2'd2, 8'd5, "R6 mode 11 freeze");
        // R11 zero idle
        wr(2'd0, 8'h01);
        wr(2'd2, 8'd0);
        tk(SRC); tk(SRC); tk(SRC);
        rd(2'd3, 8'h30, "R11 no flag from zero");
        rd(2'd2, 8'd0, "R11 count stays 0");
        idle(); idle();
        if (sb_q.size() != 0) begin
          checks++; failures++;
          $display("FAIL scoreboard: %0d reads pending expected 0", sb_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: run hung expected completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule